// File: doc/BRIEF.md
# Sized 64-bit Memory Base Address Register

This block holds one 64-bit memory base address register that a configuration bus sees as two consecutive 32-bit slots, a low word and a high word. The size of the decoded window is a parameter; the block rounds it up to a power of two and never lets it fall below one page. Every store to either slot clears the address bits that lie inside the window. Software can therefore learn the size by writing all ones and reading the slot back. The low slot always reports fixed address-space type bits in its lowest nibble.

An allocator can place the window at any time with a load strobe and a 64-bit base. The block splits that base into the two slots and applies the same masking as a configuration write. The block outputs the current aligned base. It also compares an incoming 64-bit memory address against that base and raises a hit when the address falls inside the window. Bus decode, write strobes and allocation policy belong to the surrounding logic.

Top module: `bar64_sizer`

## Requirements
- R1: The window size is the requested size (parameter `REQ_BYTES`, default 0x3000) rounded up to a power of two, and at least `PAGE_BYTES` (default 4096). With the defaults, writing 0xFFFFFFFF to the low slot reads back 0xFFFFC004.
- R2: A 4-byte write to the low slot (`cfg_sel`=0) stores the write data with every bit below log2(size) cleared, and then sets the type bits. For a memory kind (`MEM_KIND`=1) the type nibble in bits [3:0] is 0x4, meaning a 64-bit memory space. For any other kind the nibble is 0x0.
- R3: A 4-byte write to the high slot (`cfg_sel`=1) stores the write data with the bits of (size-1)>>32 cleared. With a window under 4 GiB the high slot keeps all 32 written bits.
- R4: After reset the low slot reads the type bits alone (0x00000004 for the memory kind), the high slot reads 0, and `base_o` is 0.
- R5: A cycle with `load_i` high stores `alloc_base_i[31:0]` in the low slot and `alloc_base_i[63:32]` in the high slot, with the R2 and R3 masking applied. When `load_i` and `cfg_wr` are both high in the same cycle, the load wins and the write is dropped.
- R6: A configuration write whose `cfg_bytes` is not 4 is ignored, and both slots keep their values.
- R7: `hit_o` is high in the same cycle exactly when (`mem_addr_i` AND NOT(size-1)) equals `base_o`.
- R8: `base_o` is {high slot, low slot} with the bits below log2(size) cleared, so the type bits never appear in it.
- R9: Without a load or an accepted write, both slots hold their values.
- R10: `cfg_rdata` shows the slot picked by `cfg_rsel` (0 low, 1 high) in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load strobe from the allocator |
| alloc_base_i | input | 64 | Base address to load |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Write target: 0 low slot, 1 high slot |
| cfg_bytes | input | 3 | Access width in bytes; only 4 is accepted |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rsel | input | 1 | Read target: 0 low slot, 1 high slot |
| cfg_rdata | output | 32 | Read data of the selected slot |
| mem_addr_i | input | 64 | Incoming memory address to decode |
| base_o | output | 64 | Current aligned base address |
| hit_o | output | 1 | Address falls inside the window |

## Verification
Loads and writes go through one register stage. Their effect shows on `cfg_rdata` and `base_o` just after the clock edge that captures them. The read mux and the hit comparator are combinational, so `cfg_rdata` and `hit_o` follow `cfg_rsel` and `mem_addr_i` in the same cycle. The bench therefore drives inputs on the falling edge and samples one time unit after the next rising edge for register results. For the combinational outputs it samples a short delay after changing the input, before any further edge. Checks for dropped writes read both slots back before any later stimulus.

// File: rtl/bar64_pkg.sv
package bar64_pkg;

   // Log2 of the effective window: round the request up to a power of two,
   // and never go below one page.
   function automatic int unsigned win_log2(longint unsigned req, longint unsigned page);
      int unsigned lr;
      int unsigned lp;
      lr = $clog2(req);
      lp = $clog2(page);
      return (lr > lp) ? lr : lp;
   endfunction

   // Type nibble reported in the low slot.
   localparam logic [3:0] TYPE_MEM64 = 4'h4;
   localparam logic [3:0] TYPE_NONE  = 4'h0;

   typedef enum logic {
      SLOT_LO = 1'b0,
      SLOT_HI = 1'b1
   } slot_e;

endpackage

// File: rtl/bar64_slot.sv
module bar64_slot #(
   parameter int unsigned W         = 32,
   parameter logic [31:0] KEEP_MASK = 32'hFFFF_F000,
   parameter logic [31:0] FIX_BITS  = 32'h0000_0004
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         wr,
   input  logic [W-1:0] wr_val,
   output logic [W-1:0] q
);

   localparam logic [W-1:0] KEEP = KEEP_MASK[W-1:0];
   localparam logic [W-1:0] FIX  = FIX_BITS[W-1:0];

   initial begin
      if (W != 32) $error("bar64_slot: slot width must be 32");
      if ((KEEP & FIX) != '0) $error("bar64_slot: fixed bits overlap kept bits");
   end

   logic [W-1:0] src;
   always_comb src = ld ? ld_val : wr_val;

   always_ff @(posedge clk) begin
      if (!rst_n)        q <= FIX;
      else if (ld || wr) q <= (src & KEEP) | FIX;
   end

   // R2
   fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q & ~KEEP) == FIX);

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !wr) |=> $stable(q));

   // R5
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> ((q & KEEP) == ($past(ld_val) & KEEP)));

endmodule

// File: rtl/bar64_hit_cmp.sv
module bar64_hit_cmp #(
   parameter int unsigned AW     = 64,
   parameter int unsigned LOG2SZ = 12
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] base,
   output logic          hit
);

   localparam int unsigned TAG_W = AW - LOG2SZ;

   initial begin
      if (LOG2SZ >= AW) $error("bar64_hit_cmp: window must be smaller than address space");
   end

   // Compare only the bits above the window; a generate loop forms the
   // per-bit equality so the reduction tree is explicit.
   logic [TAG_W-1:0] eq_bit;
   for (genvar g = 0; g < TAG_W; g++) begin : g_eq
      assign eq_bit[g] = (addr[LOG2SZ+g] == base[LOG2SZ+g]);
   end

   assign hit = &eq_bit;

endmodule

// File: rtl/bar64_sizer.sv
module bar64_sizer #(
   parameter longint unsigned REQ_BYTES  = 64'h3000,
   parameter longint unsigned PAGE_BYTES = 64'h1000,
   parameter bit              MEM_KIND   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load_i,
   input  logic [63:0] alloc_base_i,
   input  logic        cfg_wr,
   input  logic        cfg_sel,
   input  logic [2:0]  cfg_bytes,
   input  logic [31:0] cfg_wdata,
   input  logic        cfg_rsel,
   output logic [31:0] cfg_rdata,
   input  logic [63:0] mem_addr_i,
   output logic [63:0] base_o,
   output logic        hit_o
);
   import bar64_pkg::*;

   localparam int unsigned LOG2SZ = win_log2(REQ_BYTES, PAGE_BYTES);
   localparam logic [63:0] SZ_M1  = (64'd1 << LOG2SZ) - 64'd1;
   localparam logic [63:0] KEEP64 = ~SZ_M1;
   localparam logic [3:0]  TYPE_N = MEM_KIND ? TYPE_MEM64 : TYPE_NONE;
   localparam logic [31:0] FIX_LO = {28'd0, TYPE_N};

   initial begin
      if (REQ_BYTES == 0) $error("bar64_sizer: REQ_BYTES must be nonzero");
      if (PAGE_BYTES < 16) $error("bar64_sizer: page must leave room for type bits");
      if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0) $error("bar64_sizer: page must be a power of two");
      if (LOG2SZ > 63) $error("bar64_sizer: window too large");
   end

   logic wr_ok;
   logic wr_lo;
   logic wr_hi;
   logic [31:0] slot_lo;
   logic [31:0] slot_hi;

   // Only full 32-bit accesses reach a slot.
   assign wr_ok = cfg_wr && (cfg_bytes == 3'd4);
   assign wr_lo = wr_ok && (slot_e'(cfg_sel) == SLOT_LO);
   assign wr_hi = wr_ok && (slot_e'(cfg_sel) == SLOT_HI);

   bar64_slot #(
      .W(32), .KEEP_MASK(KEEP64[31:0]), .FIX_BITS(FIX_LO)
   ) u_lo (
      .clk(clk), .rst_n(rst_n),
      .ld(load_i), .ld_val(alloc_base_i[31:0]),
      .wr(wr_lo),  .wr_val(cfg_wdata),
      .q(slot_lo)
   );

   bar64_slot #(
      .W(32), .KEEP_MASK(KEEP64[63:32]), .FIX_BITS(32'd0)
   ) u_hi (
      .clk(clk), .rst_n(rst_n),
      .ld(load_i), .ld_val(alloc_base_i[63:32]),
      .wr(wr_hi),  .wr_val(cfg_wdata),
      .q(slot_hi)
   );

   assign base_o    = {slot_hi, slot_lo} & KEEP64;
   assign cfg_rdata = (slot_e'(cfg_rsel) == SLOT_HI) ? slot_hi : slot_lo;

   bar64_hit_cmp #(.AW(64), .LOG2SZ(LOG2SZ)) u_cmp (
      .addr(mem_addr_i), .base(base_o), .hit(hit_o)
   );

   // R6
   bad_width_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_bytes != 3'd4 && !load_i) |=> ($stable(slot_lo) && $stable(slot_hi)));

   // R8
   base_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (base_o & SZ_M1) == 64'd0);

   // R7
   self_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_addr_i == base_o) |-> hit_o);

   // R3
   hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !load_i) |=> (slot_hi == ($past(cfg_wdata) & KEEP64[63:32])));

endmodule

// File: tb/bar64_sizer_tb.sv
module bar64_sizer_tb_top;

   localparam time CLK_T = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_i = 1'b0;
   logic [63:0] alloc_base_i = '0;
   logic        cfg_wr = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [2:0]  cfg_bytes = 3'd4;
   logic [31:0] cfg_wdata = '0;
   logic        cfg_rsel = 1'b0;
   logic [31:0] cfg_rdata;
   logic [63:0] mem_addr_i = '0;
   logic [63:0] base_o;
   logic        hit_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_T/2) clk = ~clk;

   bar64_sizer dut_i (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .alloc_base_i(alloc_base_i),
      .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_bytes(cfg_bytes), .cfg_wdata(cfg_wdata),
      .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata), .mem_addr_i(mem_addr_i),
      .base_o(base_o), .hit_o(hit_o)
   );

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic rd(input bit sel, output logic [31:0] v);
      cfg_rsel = sel;
      #1;
      v = cfg_rdata;
   endtask

   // Drive on falling edge, let the rising edge capture, sample 1 unit later.
   task automatic cfg_write(bit sel, logic [2:0] nb, logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_bytes = nb; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_wr = 1'b0; cfg_bytes = 3'd4;
   endtask

   task automatic alloc_load(logic [63:0] b);
      @(negedge clk);
      load_i = 1'b1; alloc_base_i = b;
      @(posedge clk); #1;
      load_i = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(1'b0, v); check("R4 lo", v, 32'h4);
      rd(1'b1, v); check("R4 hi", v, 32'h0);
      check("R4 base", base_o, 64'h0);
   endtask

   task automatic t_probe;
      logic [31:0] v;
      cfg_write(1'b0, 3'd4, 32'hFFFF_FFFF);
      rd(1'b0, v); check("R1 size probe", v, 32'hFFFF_C004);
      cfg_write(1'b0, 3'd4, 32'h1234_5678);
      rd(1'b0, v); check("R2 lo mask", v, 32'h1234_4004);
      cfg_write(1'b0, 3'd4, 32'h0000_000B);
      rd(1'b0, v); check("R2 type bits", v, 32'h0000_0004);
      cfg_write(1'b1, 3'd4, 32'hFFFF_FFFF);
      rd(1'b1, v); check("R3 hi all ones", v, 32'hFFFF_FFFF);
      cfg_write(1'b1, 3'd4, 32'hA5A5_0001);
      rd(1'b1, v); check("R3 hi keep", v, 32'hA5A5_0001);
      check("R8 base", base_o, 64'hA5A5_0001_0000_0000);
   endtask

   task automatic t_width;
      logic [31:0] v;
      cfg_write(1'b0, 3'd4, 32'h0000_8000);
      cfg_write(1'b0, 3'd2, 32'hFFFF_FFFF);
      rd(1'b0, v); check("R6 lo width2", v, 32'h0000_8004);
      cfg_write(1'b1, 3'd1, 32'h0000_0000);
      rd(1'b1, v); check("R6 hi width1", v, 32'hA5A5_0001);
      repeat (3) @(posedge clk);
      #1;
      rd(1'b0, v); check("R9 hold lo", v, 32'h0000_8004);
   endtask

   task automatic t_load;
      logic [31:0] v;
      alloc_load(64'h0000_0001_2345_6789);
      rd(1'b0, v); check("R5 lo", v, 32'h2345_4004);
      rd(1'b1, v); check("R5 hi", v, 32'h0000_0001);
      check("R8 base load", base_o, 64'h0000_0001_2345_4000);
      @(negedge clk);
      load_i = 1'b1; alloc_base_i = 64'h0000_0002_0000_C000;
      cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_bytes = 3'd4; cfg_wdata = 32'hFFFF_FFFF;
      @(posedge clk); #1;
      load_i = 1'b0; cfg_wr = 1'b0;
      rd(1'b0, v); check("R5 load wins", v, 32'h0000_C004);
      rd(1'b1, v); check("R5 load wins hi", v, 32'h0000_0002);
   endtask

   task automatic t_hit;
      alloc_load(64'h0000_0001_2345_4000);
      mem_addr_i = 64'h0000_0001_2345_4000; #1; check("R7 base", {63'd0, hit_o}, 64'd1);
      mem_addr_i = 64'h0000_0001_2345_7FFF; #1; check("R7 top", {63'd0, hit_o}, 64'd1);
      mem_addr_i = 64'h0000_0001_2345_8000; #1; check("R7 above", {63'd0, hit_o}, 64'd0);
      mem_addr_i = 64'h0000_0001_2345_3FFF; #1; check("R7 below", {63'd0, hit_o}, 64'd0);
      mem_addr_i = 64'h0000_0000_2345_4000; #1; check("R7 hi differs", {63'd0, hit_o}, 64'd0);
   endtask

   task automatic t_rsel;
      logic [31:0] v;
      rd(1'b1, v); check("R10 hi", v, 32'h0000_0001);
      rd(1'b0, v); check("R10 lo", v, 32'h2345_4004);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_probe();
      t_width();
      t_load();
      t_hit();
      t_rsel();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_T * 20000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=hung exp=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule